// File: doc/BRIEF.md
# Pipelined Rectangular-to-Polar Converter

This block turns a signed rectangular vector (x, y) into polar form. It returns the angle of the vector and its length. The length is scaled by the fixed shift-add rotation gain. No multiplier is used. Each pipeline stage applies a micro-rotation by atan(2^-i). The stage picks the direction of that rotation from the sign of its current y, so y is driven toward zero while an angle register collects the sum of the rotations applied. When the last stage finishes, the surviving x is the scaled length and the angle register holds atan2(y, x).

Vectors with a negative x lie outside the range where the iteration converges. A quarter-turn fold at the pipeline entry handles them. The fold swaps x and y, negates one of them, and preloads the angle register with plus or minus 90 degrees. The sign of y decides which direction of fold is used. The pipeline is fully unrolled, so it takes one sample on every clock and gives each result after a fixed latency equal to the number of stages. A valid bit travels with every sample.

Inputs are 16-bit signed Q2.14 values. The angle output is a 16-bit signed binary angle: a full turn is 65536 counts, zero lies on the +x axis, and positive angles run counterclockwise.

Top module: `cordic_vec`

## Requirements
- R1: For a valid input with magnitude between 0.3 and 1.2, `out_angle` equals atan2(y, x) within ±12 counts. The angle scale is 65536 counts per turn, with +16384 = +90° and 0 = the +x axis.
- R2: `out_mag` is an unsigned-valued Q2.14 number equal to sqrt(x²+y²) times the rotation gain, the product of sqrt(1+2^-2i) over the 14 stages (about 1.6468). It is accurate within ±8 LSB.
- R3: Inputs with negative x, in the second and third quadrants, go through the quarter-turn fold and meet R1 and R2. An angle at ±180° appears modulo 65536, so −32768 stands for 180°.
- R4: Points on each of the four axes give 0, +16384, −32768 and −16384 counts, within the R1 tolerance.
- R5: A sample accepted at a rising edge appears on the outputs with `out_valid` high exactly 14 rising edges later, and a new sample is accepted on every clock.
- R6: A clock with `in_valid` low produces a clock with `out_valid` low 14 edges later. Neighbouring valid samples are not disturbed.
- R7: A synchronous active-high `rst` clears every stage's valid bit: `out_valid` is low after any edge where `rst` is high. After release, no stale sample comes out.
- R8: Input magnitudes up to 1.2 do not overflow. The scaled magnitude (up to about 1.98) stays correct within R2 tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_x | input | 16 | Signed Q2.14 x coordinate |
| in_y | input | 16 | Signed Q2.14 y coordinate |
| out_valid | output | 1 | Result present |
| out_angle | output | 16 | Signed binary angle, 65536 counts per turn |
| out_mag | output | 16 | Gain-scaled magnitude, Q2.14 |

## Verification
The hardest cases to reach from the ports lie along the negative x axis. There the fold direction flips with the sign of y, and the true angle wraps between +32767 and −32768 counts. A fine sweep around the whole circle, plus points placed exactly on and next to that axis, drives the fold through both branches and across the wrap. Reset is applied while every stage holds a valid sample. This shows that no stale result escapes after release. A behavioural queue model, built on real-valued atan2 and square root, is compared against the outputs on every clock.

// File: rtl/cordic_vec_pkg.sv
package cordic_vec_pkg;

  // Micro-rotation angle atan(2^-i) expressed in binary angle counts
  // for an aw-bit full turn, rounded to nearest.
  function automatic int rot_counts(input int i, input int aw);
    real ang;
    real turn;
    ang  = $atan(2.0 ** (-i));
    turn = 2.0 * 3.14159265358979323846;
    return int'(ang / turn * (2.0 ** aw));
  endfunction

endpackage

// File: rtl/cordic_vec_fold.sv
module cordic_vec_fold #(
  parameter int W     = 16,
  parameter int GUARD = 2,
  parameter int IW    = W + 1 + GUARD,
  parameter int AW    = 16
) (
  input  logic signed [W-1:0]  x_in,
  input  logic signed [W-1:0]  y_in,
  output logic signed [IW-1:0] x_out,
  output logic signed [IW-1:0] y_out,
  output logic        [AW-1:0] z_out
);
  localparam int HEAD = IW - W - GUARD;
  localparam logic [AW-1:0] PLUS_QTR  = {2'b01, {(AW-2){1'b0}}};
  localparam logic [AW-1:0] MINUS_QTR = {2'b11, {(AW-2){1'b0}}};

  logic signed [IW-1:0] xe, ye;

  // Widen: headroom bits on top, guard bits below the binary point.
  assign xe = {{HEAD{x_in[W-1]}}, x_in, {GUARD{1'b0}}};
  assign ye = {{HEAD{y_in[W-1]}}, y_in, {GUARD{1'b0}}};

  always_comb begin
    if (!xe[IW-1]) begin
      x_out = xe;
      y_out = ye;
      z_out = '0;
    end else if (!ye[IW-1]) begin
      // Left half, upper side: turn by -90 degrees.
      x_out = ye;
      y_out = -xe;
      z_out = PLUS_QTR;
    end else begin
      // Left half, lower side: turn by +90 degrees.
      x_out = -ye;
      y_out = xe;
      z_out = MINUS_QTR;
    end
  end

endmodule

// File: rtl/cordic_vec_stage.sv
module cordic_vec_stage
  import cordic_vec_pkg::*;
#(
  parameter int IW  = 19,
  parameter int AW  = 16,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic signed [IW-1:0] x_in,
  input  logic signed [IW-1:0] y_in,
  input  logic        [AW-1:0] z_in,
  output logic                 v_q,
  output logic signed [IW-1:0] x_q,
  output logic signed [IW-1:0] y_q,
  output logic        [AW-1:0] z_q
);
  localparam int ROT_I = rot_counts(IDX, AW);
  localparam logic [AW-1:0] ROT = ROT_I[AW-1:0];

  logic signed [IW-1:0] xsh, ysh, x_n, y_n;
  logic        [AW-1:0] z_n;

  assign xsh = x_in >>> IDX;
  assign ysh = y_in >>> IDX;

  always_comb begin
    if (y_in[IW-1]) begin
      x_n = x_in - ysh;
      y_n = y_in + xsh;
      z_n = z_in - ROT;
    end else begin
      x_n = x_in + ysh;
      y_n = y_in - xsh;
      z_n = z_in + ROT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_in;
    x_q <= x_n;
    y_q <= y_n;
    z_q <= z_n;
  end

  // R5: the valid bit moves one stage per clock.
  a_r5_valid_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (v_q == $past(v_in)));

  // R7: reset empties this stage.
  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> !v_q);

  // R2: with x non-negative, every micro-rotation lengthens x.
  a_r2_x_monotonic: assert property (@(posedge clk) disable iff (rst)
    v_in |=> (x_q >= $past(x_in)));

endmodule

// File: rtl/cordic_vec.sv
module cordic_vec #(
  parameter int W      = 16,
  parameter int STAGES = 14,
  parameter int AW     = 16,
  parameter int GUARD  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [W-1:0]      in_x,
  input  logic [W-1:0]      in_y,
  output logic              out_valid,
  output logic [AW-1:0]     out_angle,
  output logic [W-1:0]      out_mag
);
  localparam int IW = W + 1 + GUARD;

  logic [STAGES:0]      v_c;
  logic signed [IW-1:0] x_c [STAGES+1];
  logic signed [IW-1:0] y_c [STAGES+1];
  logic        [AW-1:0] z_c [STAGES+1];

  assign v_c[0] = in_valid;

  cordic_vec_fold #(.W(W), .GUARD(GUARD), .IW(IW), .AW(AW)) u_fold (
    .x_in  ($signed(in_x)),
    .y_in  ($signed(in_y)),
    .x_out (x_c[0]),
    .y_out (y_c[0]),
    .z_out (z_c[0])
  );

  // R3: after the fold, x never enters the pipeline negative.
  a_r3_fold_nonneg: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !x_c[0][IW-1]);

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    cordic_vec_stage #(.IW(IW), .AW(AW), .IDX(k)) u_stage (
      .clk  (clk),
      .rst  (rst),
      .v_in (v_c[k]),
      .x_in (x_c[k]),
      .y_in (y_c[k]),
      .z_in (z_c[k]),
      .v_q  (v_c[k+1]),
      .x_q  (x_c[k+1]),
      .y_q  (y_c[k+1]),
      .z_q  (z_c[k+1])
    );
  end

  // Outputs come straight from the last stage's registers.
  assign out_valid = v_c[STAGES];
  assign out_angle = z_c[STAGES];
  assign out_mag   = x_c[STAGES][W+GUARD-1:GUARD];

  logic unused_tail;
  assign unused_tail = ^{y_c[STAGES], x_c[STAGES][IW-1], x_c[STAGES][GUARD-1:0]};

endmodule

// File: tb/tb_cordic_vec.sv
module tb_cordic_vec;
  localparam int W      = 16;
  localparam int STAGES = 14;
  localparam real SCALE = 16384.0;
  localparam real PI    = 3.14159265358979323846;
  localparam int ANG_TOL = 12;
  localparam int MAG_TOL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_x = '0;
  logic [W-1:0] in_y = '0;
  logic out_valid;
  logic [15:0] out_angle;
  logic [W-1:0] out_mag;

  int checks = 0;
  int failures = 0;
  real gain;

  typedef struct {
    bit    v;
    int    ang;
    int    mag;
    string tag;
    string mtag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  cordic_vec dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_angle(out_angle), .out_mag(out_mag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic prefill();
    exp_t e;
    q.delete();
    e.v = 1'b0; e.ang = 0; e.mag = 0; e.tag = "R7"; e.mtag = "R7";
    for (int i = 0; i < STAGES; i++) q.push_back(e);
  endtask

  task automatic compare_out();
    exp_t e;
    int d;
    if (q.size() == STAGES) begin
      e = q.pop_front();
      check(out_valid == e.v, e.v ? "R5" : "R6", "out_valid", int'(out_valid), int'(e.v));
      if (e.v && out_valid) begin
        d = int'($signed(out_angle)) - e.ang;
        d = ((d + 32768) % 65536 + 65536) % 65536 - 32768;
        check(d <= ANG_TOL && d >= -ANG_TOL, e.tag, "angle",
              int'($signed(out_angle)), e.ang);
        d = int'(out_mag) - e.mag;
        check(d <= MAG_TOL && d >= -MAG_TOL, e.mtag, "magnitude",
              int'(out_mag), e.mag);
      end
    end
  endtask

  task automatic step(input bit v, input int xi, input int yi);
    exp_t e;
    real xr, yr, a;
    int ai;
    @(negedge clk);
    compare_out();
    rst = 1'b0;
    in_valid = v;
    in_x = xi[W-1:0];
    in_y = yi[W-1:0];
    xr = real'(xi) / SCALE;
    yr = real'(yi) / SCALE;
    a  = $atan2(yr, xr) / (2.0 * PI) * 65536.0;
    ai = int'(a);
    if (ai >= 32768) ai -= 65536;
    e.v   = v;
    e.ang = ai;
    e.mag = int'($sqrt(xr * xr + yr * yr) * gain * SCALE);
    if (xi == 0 || yi == 0)  e.tag = "R4";
    else if (xi < 0)         e.tag = "R3";
    else                     e.tag = "R1";
    e.mtag = ($sqrt(xr * xr + yr * yr) > 1.1) ? "R8" : "R2";
    q.push_back(e);
  endtask

  task automatic polar(input bit v, input real r, input real deg);
    step(v, int'(r * $cos(deg * PI / 180.0) * SCALE),
            int'(r * $sin(deg * PI / 180.0) * SCALE));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    gain = 1.0;
    for (int i = 0; i < STAGES; i++) gain = gain * $sqrt(1.0 + 2.0 ** (-2 * i));

    // R7: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
    prefill();

    // R4: axes
    step(1, 14746, 0);
    step(1, 0, 14746);
    step(1, -14746, 0);
    step(1, 0, -14746);
    // R3: quadrants and points near the negative x axis
    step(1, 9000, 7000);
    step(1, -9000, 7000);
    step(1, -9000, -7000);
    step(1, 9000, -7000);
    step(1, -12000, 1);
    step(1, -12000, -1);
    step(1, 6000, 6000);
    step(1, -6000, -6000);

    // R8: large-magnitude sweep, back to back (R5)
    for (int k = 0; k < 96; k++) polar(1, 1.19, real'(k) * 3.75 - 180.0);

    // R6: bubbles between valid samples
    for (int k = 0; k < 64; k++) polar(k % 3 != 1, 0.4, real'(k) * 5.625 + 1.0);

    // R1: medium radius fine sweep
    for (int k = 0; k < 72; k++) polar(1, 0.75, real'(k) * 5.0 + 0.3);

    // R7: reset with every stage full of valid samples
    @(negedge clk);
    compare_out();
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid after mid-stream reset", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid held in reset", int'(out_valid), 0);
    prefill();

    for (int k = 0; k < 24; k++) polar(1, 1.0, real'(k) * 15.0 + 7.0);
    for (int k = 0; k < STAGES + 2; k++) step(0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule